// File: doc/BRIEF.md
# DDR Rank and Bank Address Decoder

This block sits between the system address path and a DDR memory controller with two ranks. Each cycle it may be given a 36-bit physical address together with a valid strobe. One cycle later it reports whether the address falls in the DDR window. On a hit it says which of the two active-low rank selects to drive, and it splits the offset inside that rank into internal bank, row and column fields. It also marks accesses that land in an optional half-width (32-bit) area that starts at the bottom of rank 0. The rest of rank 0 and all of rank 1 stay 64-bit.

The memory map comes from static configuration inputs:
- The window base is given as a lower part covering address bits 31..27 (128 MB granules) and an upper part covering bits 35..32.
- The size of one rank is a power-of-two code.
- A one- or two-rank population is selected.
- The half-width area has a size in MB.
- A flag says the whole data bus is 32 bits wide.
- A flag selects the device density: 4 or 8 internal banks.

Illegal combinations raise a registered configuration-error flag, and no address decodes while it is set.

Top module: `ddr_addr_decode`

## Requirements
- R1: While reset is low at a clock edge, the outputs take their reset values on that edge: `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_narrow` and `cfg_err` are 0, `rsp_cs_n` is 2'b11, and bank, row and column are 0.
- R2: All response outputs are registered. `rsp_valid` follows `req_valid` one cycle later. A cycle without `req_valid` gives `rsp_hit`=0, `rsp_miss`=0, `rsp_cs_n`=2'b11 and zero address fields.
- R3: The window is defined as follows:
  - The base is {`cfg_base_hi`, `cfg_base_lo`, 27 zero bits}.
  - The rank size is 2^(27+`cfg_size_code`) bytes (code 0 is 128 MB, code 5 is 4 GB).
  - The total size is the rank size times 1, or times 2 when `cfg_two_rank`=1.
  - An address A with base <= A < base+total is a hit.
  - Rank 0 covers the first rank size and drives `rsp_cs_n`=2'b10. Rank 1 begins at base plus the rank size and drives `rsp_cs_n`=2'b01.
- R4: A valid address outside the window gives `rsp_miss`=1, `rsp_hit`=0, `rsp_cs_n`=2'b11, `rsp_narrow`=0 and zero bank, row and column.
- R5: A base that is not a multiple of the total size sets `cfg_err` one cycle after the configuration is applied.
- R6: `cfg_err` is set when the window would cross a 4 GB boundary (its first and last byte differ in bits 35..32), or when `cfg_size_code` is above 5.
- R7: With `cfg_bus32`=0, `cfg_err` is set when `cfg_narrow_mb` exceeds half the rank size expressed in MB.
- R8: While the configuration is in error, every valid address is reported as a miss.
- R9: With `cfg_bus32`=0, `rsp_narrow`=1 exactly for rank-0 hits whose in-rank offset is below `cfg_narrow_mb` x 2^20. A value of 0 leaves rank 0 entirely 64-bit.
- R10: With `cfg_bus32`=1, `cfg_narrow_mb` is ignored. It never raises `cfg_err`, and `rsp_narrow` stays 0.
- R11: The in-rank byte offset is split as follows:
  - Bits 2..0 are the byte within a beat and are dropped.
  - `rsp_col` is offset/8 mod 1024.
  - `rsp_bank` is offset/8192 mod N, where N is 4 when `cfg_eight_bank`=0 (bit 2 then reads 0) and 8 when it is 1.
  - `rsp_row` is offset/(8192*N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Address strobe |
| req_addr | input | 36 | System physical byte address |
| cfg_base_lo | input | 5 | Base address bits 31..27 |
| cfg_base_hi | input | 4 | Base address bits 35..32 |
| cfg_size_code | input | 3 | Rank size exponent, 0 = 128 MB ... 5 = 4 GB |
| cfg_two_rank | input | 1 | 1 when both ranks are populated |
| cfg_narrow_mb | input | 12 | Half-width area size in MB at the start of rank 0 |
| cfg_bus32 | input | 1 | Data bus is 32 bits wide |
| cfg_eight_bank | input | 1 | 1: 8 internal banks (1-2 Gbit parts), 0: 4 banks (512 Mbit) |
| rsp_valid | output | 1 | Response valid, one cycle after the strobe |
| rsp_hit | output | 1 | Address lies in the DDR window |
| rsp_miss | output | 1 | Valid address outside the window or configuration in error |
| rsp_cs_n | output | 2 | Active-low rank selects, bit r for rank r |
| rsp_narrow | output | 1 | Access falls in the 32-bit area |
| rsp_bank | output | 3 | Internal bank index |
| rsp_row | output | 17 | Row index |
| rsp_col | output | 10 | Column index |
| cfg_err | output | 1 | Registered configuration-error flag |

## Verification
The bound assertions watch properties that hold on every cycle:
- at most one rank select is low, and never on a miss;
- hit and miss are exclusive;
- the response follows the strobe by one cycle;
- a configuration error always yields a miss;
- the narrow flag appears only with rank 0 on a 64-bit bus;
- bank bit 2 stays low for four-bank parts.

Whether the window limits, the rank split point, the row/bank/column values and each error condition are numerically right can only be shown by the bench. It sweeps rank sizes, rank counts, densities and bases, probing addresses at the window and rank edges, and runs directed illegal configurations.

// File: rtl/ddr_dec_pkg.sv
// Package: shared constants for the DDR address decoder.
// Assumes byte addressing and a 64-bit beat (8 bytes).
package ddr_dec_pkg;
    localparam int unsigned PHYS_AW    = 36; // physical address width
    localparam int unsigned GRAN_EXP   = 27; // 128 MB granule exponent
    localparam int unsigned SPLIT_BIT  = 32; // 4 GB boundary bit
    localparam int unsigned MAX_CODE   = 5;  // largest legal rank-size code (4 GB)
    localparam int unsigned BEAT_SHIFT = 3;  // byte-in-beat bits
    localparam int unsigned COL_BITS   = 10; // column width
    localparam int unsigned MB_SHIFT   = 20; // bytes per MB exponent
endpackage

// File: rtl/ddr_cfg_check.sv
// Module: ddr_cfg_check
// Builds the window base, rank size and total size from the configuration
// inputs and flags illegal settings: bad size code, base not aligned to the
// total size, a window crossing a 4 GB line, or an oversized narrow area.
// Assumes configuration is quasi-static; purely combinational.
module ddr_cfg_check #(
    parameter int unsigned ADDR_W   = 36,
    parameter int unsigned GRAN_W   = 27,
    parameter int unsigned SPLIT    = 32,
    parameter int unsigned CODE_W   = 3,
    parameter int unsigned MB_W     = 12,
    parameter int unsigned MAX_CODE = 5,
    parameter int unsigned MB_SHIFT = 20
) (
    input  logic [SPLIT-GRAN_W-1:0]  base_lo,
    input  logic [ADDR_W-SPLIT-1:0]  base_hi,
    input  logic [CODE_W-1:0]        size_code,
    input  logic                     two_rank,
    input  logic [MB_W-1:0]          narrow_mb,
    input  logic                     bus32,
    output logic [ADDR_W:0]          base_x,
    output logic [ADDR_W:0]          size_x,
    output logic [ADDR_W:0]          total_x,
    output logic                     err
);
    localparam int unsigned HALF_W = GRAN_W - MB_SHIFT + (1 << CODE_W);

    logic [ADDR_W:0]   last_x;
    logic [HALF_W-1:0] half_mb;
    logic [HALF_W-1:0] narrow_ext;
    logic code_bad, align_bad, cross_bad, narrow_bad;

    // Derive window geometry from configuration.
    always_comb begin
        base_x  = {1'b0, base_hi, base_lo, {GRAN_W{1'b0}}};
        size_x  = {{ADDR_W{1'b0}}, 1'b1} << (GRAN_W + int'(size_code));
        total_x = two_rank ? (size_x << 1) : size_x;
        last_x  = base_x + total_x - {{ADDR_W{1'b0}}, 1'b1};
    end

    // Evaluate each illegal-configuration condition.
    always_comb begin
        half_mb    = {{(HALF_W-1){1'b0}}, 1'b1} << (GRAN_W - MB_SHIFT - 1 + int'(size_code));
        narrow_ext = {{(HALF_W-MB_W){1'b0}}, narrow_mb};
        code_bad   = (int'(size_code) > int'(MAX_CODE));
        align_bad  = |(base_x & (total_x - {{ADDR_W{1'b0}}, 1'b1}));
        cross_bad  = (base_x[ADDR_W:SPLIT] != last_x[ADDR_W:SPLIT]);
        narrow_bad = !bus32 && (narrow_ext > half_mb);
        err        = code_bad | align_bad | cross_bad | narrow_bad;
    end
endmodule

// File: rtl/ddr_rank_match.sv
// Module: ddr_rank_match
// Compares the request address with the window, picks the rank and the
// byte offset inside it, and decides whether the access is in the
// half-width area at the start of rank 0. Assumes geometry from
// ddr_cfg_check; a configuration error suppresses every hit.
module ddr_rank_match #(
    parameter int unsigned ADDR_W   = 36,
    parameter int unsigned MB_W     = 12,
    parameter int unsigned MB_SHIFT = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W:0]   base_x,
    input  logic [ADDR_W:0]   size_x,
    input  logic [ADDR_W:0]   total_x,
    input  logic              cfg_bad,
    input  logic [MB_W-1:0]   narrow_mb,
    input  logic              bus32,
    output logic              hit,
    output logic              rank_sel,
    output logic              narrow,
    output logic [ADDR_W-1:0] rank_off
);
    localparam int unsigned PAD_W = ADDR_W + 1 - MB_W - MB_SHIFT;

    logic [ADDR_W:0] addr_x, end_x, rel_x, in_rank_x, narrow_lim;

    // Window compare, rank choice and in-rank offset.
    always_comb begin
        addr_x     = {1'b0, addr};
        end_x      = base_x + total_x;
        hit        = !cfg_bad && (addr_x >= base_x) && (addr_x < end_x);
        rel_x      = addr_x - base_x;
        rank_sel   = (rel_x >= size_x);
        in_rank_x  = rank_sel ? (rel_x - size_x) : rel_x;
        narrow_lim = {{PAD_W{1'b0}}, narrow_mb, {MB_SHIFT{1'b0}}};
        narrow     = hit && !rank_sel && !bus32 && (in_rank_x < narrow_lim);
        rank_off   = in_rank_x[ADDR_W-1:0];
    end
endmodule

// File: rtl/ddr_offset_split.sv
// Module: ddr_offset_split
// Splits an in-rank byte offset into column (low), internal bank, then row.
// The bank field is 2 or 3 bits wide by device density. Assumes the
// offset is already below the rank size, so the row is naturally bounded.
module ddr_offset_split #(
    parameter int unsigned ADDR_W     = 36,
    parameter int unsigned BEAT_SHIFT = 3,
    parameter int unsigned COL_W      = 10,
    parameter int unsigned ROW_W      = 17,
    parameter int unsigned BANK_W     = 3
) (
    input  logic [ADDR_W-1:0] off,
    input  logic              eight_bank,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    localparam int unsigned LOW_W = BEAT_SHIFT + COL_W;

    logic [ADDR_W-1:0] upper;

    // Field extraction for both bank-count variants.
    always_comb begin
        col   = off[BEAT_SHIFT +: COL_W];
        upper = off >> LOW_W;
        if (eight_bank) begin
            bank = upper[BANK_W-1:0];
            row  = ROW_W'(upper >> BANK_W);
        end else begin
            bank = {1'b0, upper[BANK_W-2:0]};
            row  = ROW_W'(upper >> (BANK_W-1));
        end
    end
endmodule

// File: rtl/ddr_addr_decode.sv
// Module: ddr_addr_decode (top)
// Two-rank DDR address decoder. The window geometry and the error check
// come from ddr_cfg_check, the hit and rank from ddr_rank_match, and the
// bank/row/column from ddr_offset_split. All outputs are registered one
// cycle after the request. Assumes configuration inputs change only
// between transactions.
module ddr_addr_decode
    import ddr_dec_pkg::*;
#(
    parameter int unsigned ADDR_W = PHYS_AW,
    parameter int unsigned CODE_W = 3,
    parameter int unsigned MB_W   = 12,
    parameter int unsigned RANKS  = 2,
    parameter int unsigned BANK_W = 3,
    parameter int unsigned COL_W  = COL_BITS,
    parameter int unsigned ROW_W  = GRAN_EXP + MAX_CODE - BEAT_SHIFT - COL_BITS - 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [SPLIT_BIT-GRAN_EXP-1:0] cfg_base_lo,
    input  logic [ADDR_W-SPLIT_BIT-1:0]   cfg_base_hi,
    input  logic [CODE_W-1:0]             cfg_size_code,
    input  logic                          cfg_two_rank,
    input  logic [MB_W-1:0]               cfg_narrow_mb,
    input  logic                          cfg_bus32,
    input  logic                          cfg_eight_bank,
    output logic                          rsp_valid,
    output logic                          rsp_hit,
    output logic                          rsp_miss,
    output logic [RANKS-1:0]              rsp_cs_n,
    output logic                          rsp_narrow,
    output logic [BANK_W-1:0]             rsp_bank,
    output logic [ROW_W-1:0]              rsp_row,
    output logic [COL_W-1:0]              rsp_col,
    output logic                          cfg_err
);
    logic [ADDR_W:0]     base_x, size_x, total_x;
    logic                err_d, hit_d, rank_d, narrow_d;
    logic [ADDR_W-1:0]   off_d;
    logic [BANK_W-1:0]   bank_d;
    logic [ROW_W-1:0]    row_d;
    logic [COL_W-1:0]    col_d;
    logic [RANKS-1:0]    cs_d;

    ddr_cfg_check #(
        .ADDR_W(ADDR_W), .GRAN_W(GRAN_EXP), .SPLIT(SPLIT_BIT), .CODE_W(CODE_W),
        .MB_W(MB_W), .MAX_CODE(MAX_CODE), .MB_SHIFT(MB_SHIFT)
    ) u_cfg (
        .base_lo(cfg_base_lo), .base_hi(cfg_base_hi), .size_code(cfg_size_code),
        .two_rank(cfg_two_rank), .narrow_mb(cfg_narrow_mb), .bus32(cfg_bus32),
        .base_x(base_x), .size_x(size_x), .total_x(total_x), .err(err_d)
    );

    ddr_rank_match #(
        .ADDR_W(ADDR_W), .MB_W(MB_W), .MB_SHIFT(MB_SHIFT)
    ) u_match (
        .addr(req_addr), .base_x(base_x), .size_x(size_x), .total_x(total_x),
        .cfg_bad(err_d), .narrow_mb(cfg_narrow_mb), .bus32(cfg_bus32),
        .hit(hit_d), .rank_sel(rank_d), .narrow(narrow_d), .rank_off(off_d)
    );

    ddr_offset_split #(
        .ADDR_W(ADDR_W), .BEAT_SHIFT(BEAT_SHIFT), .COL_W(COL_W),
        .ROW_W(ROW_W), .BANK_W(BANK_W)
    ) u_split (
        .off(off_d), .eight_bank(cfg_eight_bank),
        .bank(bank_d), .row(row_d), .col(col_d)
    );

    // One active-low select per rank, low only for the addressed rank.
    for (genvar r = 0; r < RANKS; r++) begin : g_cs
        assign cs_d[r] = !(hit_d && (rank_d == 1'(r)));
    end

    // Register the response and the configuration-error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_cs_n   <= '1;
            rsp_narrow <= 1'b0;
            rsp_bank   <= '0;
            rsp_row    <= '0;
            rsp_col    <= '0;
            cfg_err    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            cfg_err   <= err_d;
            if (req_valid && hit_d) begin
                rsp_hit    <= 1'b1;
                rsp_miss   <= 1'b0;
                rsp_cs_n   <= cs_d;
                rsp_narrow <= narrow_d;
                rsp_bank   <= bank_d;
                rsp_row    <= row_d;
                rsp_col    <= col_d;
            end else begin
                rsp_hit    <= 1'b0;
                rsp_miss   <= req_valid;
                rsp_cs_n   <= '1;
                rsp_narrow <= 1'b0;
                rsp_bank   <= '0;
                rsp_row    <= '0;
                rsp_col    <= '0;
            end
        end
    end
endmodule

// File: rtl/ddr_addr_decode_chk.sv
// Module: ddr_addr_decode_chk
// Cycle-level properties of the decoder's outputs, bound to the top.
module ddr_addr_decode_chk #(
    parameter int unsigned RANKS  = 2,
    parameter int unsigned BANK_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              cfg_bus32,
    input logic              cfg_eight_bank,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic [RANKS-1:0]  rsp_cs_n,
    input logic              rsp_narrow,
    input logic [BANK_W-1:0] rsp_bank,
    input logic              cfg_err
);
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss && (&rsp_cs_n)));
    assert_single_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~rsp_cs_n));
    assert_hit_drives_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> ($countones(~rsp_cs_n) == 1));
    assert_miss_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> ((&rsp_cs_n) && !rsp_hit && !rsp_narrow));
    assert_err_forces_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cfg_err) |-> rsp_miss);
    assert_narrow_rank0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_narrow |-> (rsp_hit && !rsp_cs_n[0] && rsp_cs_n[1]));
    assert_bus32_no_narrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_bus32) |-> !rsp_narrow);
    assert_four_bank_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_eight_bank) |-> !rsp_bank[BANK_W-1]);
endmodule

bind ddr_addr_decode ddr_addr_decode_chk #(.RANKS(RANKS), .BANK_W(BANK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cfg_bus32(cfg_bus32),
    .cfg_eight_bank(cfg_eight_bank), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_cs_n(rsp_cs_n), .rsp_narrow(rsp_narrow),
    .rsp_bank(rsp_bank), .cfg_err(cfg_err)
);

// File: tb/ddr_addr_decode_bench.sv
// Bench: sweeps rank size, rank count, density and base, probes edge
// addresses, and runs directed illegal configurations. Expected values
// come from arithmetic on the requirement formulas.
module ddr_addr_decode_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [35:0] req_addr = '0;
    logic [4:0]  cfg_base_lo = '0;
    logic [3:0]  cfg_base_hi = '0;
    logic [2:0]  cfg_size_code = '0;
    logic        cfg_two_rank = 1'b0;
    logic [11:0] cfg_narrow_mb = '0;
    logic        cfg_bus32 = 1'b0;
    logic        cfg_eight_bank = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_narrow, cfg_err;
    logic [1:0]  rsp_cs_n;
    logic [2:0]  rsp_bank;
    logic [16:0] rsp_row;
    logic [9:0]  rsp_col;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    longint unsigned m_base;
    int              m_code;
    bit              m_two, m_eight, m_bus32;
    longint unsigned m_nmb;

    always #10 clk = ~clk; // 50 MHz

    ddr_addr_decode u_ddr_addr_decode (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .cfg_base_lo(cfg_base_lo), .cfg_base_hi(cfg_base_hi),
        .cfg_size_code(cfg_size_code), .cfg_two_rank(cfg_two_rank),
        .cfg_narrow_mb(cfg_narrow_mb), .cfg_bus32(cfg_bus32),
        .cfg_eight_bank(cfg_eight_bank), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_cs_n(rsp_cs_n), .rsp_narrow(rsp_narrow),
        .rsp_bank(rsp_bank), .rsp_row(rsp_row), .rsp_col(rsp_col), .cfg_err(cfg_err)
    );

    function automatic logic [36:0] got_vec();
        return {rsp_valid, rsp_hit, rsp_miss, rsp_cs_n, rsp_narrow,
                rsp_bank, rsp_row, rsp_col, cfg_err};
    endfunction

    function automatic bit model_err();
        longint unsigned size = 64'd1 << (27 + m_code);
        longint unsigned total = m_two ? 2 * size : size;
        if (m_code > 5) return 1;
        if (m_base % total != 0) return 1;
        if ((m_base >> 32) != ((m_base + total - 1) >> 32)) return 1;
        if (!m_bus32 && (m_nmb * 64'd1048576 > size / 2)) return 1;
        return 0;
    endfunction

    function automatic logic [36:0] model(input bit vld, input longint unsigned a);
        longint unsigned size = 64'd1 << (27 + m_code);
        longint unsigned total = m_two ? 2 * size : size;
        longint unsigned rel, off, nb;
        bit err = model_err();
        bit hit, rk, nar;
        logic [1:0] cs;
        logic [2:0] bank;
        logic [16:0] row;
        logic [9:0] col;
        hit = vld && !err && (a >= m_base) && (a < m_base + total);
        cs = 2'b11; nar = 0; bank = '0; row = '0; col = '0;
        if (hit) begin
            rel  = a - m_base;
            rk   = (rel >= size);
            off  = rk ? rel - size : rel;
            nb   = m_eight ? 8 : 4;
            col  = 10'((off / 8) % 1024);
            bank = 3'((off / 8192) % nb);
            row  = 17'(off / (8192 * nb));
            cs   = rk ? 2'b01 : 2'b10;
            nar  = !rk && !m_bus32 && (off < m_nmb * 64'd1048576);
        end
        return {vld, hit, vld && !hit, cs, nar, bank, row, col, err};
    endfunction

    task automatic check(input string tag, input logic [36:0] got, input logic [36:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic set_cfg(input longint unsigned base, input int code, input bit two,
                           input bit eight, input longint unsigned nmb, input bit b32);
        m_base = base; m_code = code; m_two = two; m_eight = eight;
        m_nmb = nmb; m_bus32 = b32;
        cfg_base_lo    = base[31:27];
        cfg_base_hi    = base[35:32];
        cfg_size_code  = 3'(code);
        cfg_two_rank   = two;
        cfg_eight_bank = eight;
        cfg_narrow_mb  = 12'(nmb);
        cfg_bus32      = b32;
    endtask

    // Drive at the falling edge, sample at the next falling edge.
    task automatic probe(input string tag, input longint unsigned a);
        req_valid = 1'b1;
        req_addr  = 36'(a);
        @(negedge clk);
        check(tag, got_vec(), model(1'b1, a));
    endtask

    task automatic idle(input string tag);
        req_valid = 1'b0;
        @(negedge clk);
        check(tag, got_vec(), model(1'b0, 0));
    endtask

    function automatic string tag_of(input longint unsigned a);
        longint unsigned size = 64'd1 << (27 + m_code);
        longint unsigned total = m_two ? 2 * size : size;
        if (model_err()) return "R8";
        if (a >= m_base && a < m_base + total) return "R3 R11";
        return "R4";
    endfunction

    task automatic sweep_addrs();
        longint unsigned size = 64'd1 << (27 + m_code);
        longint unsigned total = m_two ? 2 * size : size;
        longint unsigned pts[8];
        pts[0] = m_base; pts[1] = m_base + size - 1; pts[2] = m_base + size;
        pts[3] = m_base + total - 1; pts[4] = m_base + total;
        pts[5] = (m_base == 0) ? 64'h8 : m_base - 1;
        pts[6] = m_base + 64'h3FF8; pts[7] = m_base + 64'h12000;
        for (int i = 0; i < 8; i++)
            if (pts[i] < 64'h10_0000_0000) probe(tag_of(pts[i]), pts[i]);
        for (int k = 1; k <= 6; k++) begin
            longint unsigned a = m_base + (k * 64'h1234_5678 + 64'h89AB8) % total;
            probe(tag_of(a), a);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int codes[4] = '{0, 1, 2, 5};
        set_cfg(64'h1_0000_0000, 0, 1, 0, 0, 0);
        req_valid = 1'b1; req_addr = 36'h1_0000_0000;
        repeat (3) @(negedge clk);
        check("R1 reset", got_vec(), {3'b000, 2'b11, 1'b0, 30'd0, 1'b0});
        rst_n = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        idle("R2 idle");

        // Sweep of the legal and illegal geometry space.
        for (int ci = 0; ci < 4; ci++)
            for (int two = 0; two < 2; two++)
                for (int eight = 0; eight < 2; eight++)
                    for (int j = 0; j < 3; j++) begin
                        longint unsigned total = (64'd1 << (27 + codes[ci])) * (two ? 2 : 1);
                        longint unsigned mult = (j == 0) ? 0 : (j == 1) ? 1 : 5;
                        set_cfg(total * mult, codes[ci], 1'(two), 1'(eight), 16, 0);
                        sweep_addrs();
                        idle("R2 gap");
                    end

        // R5: base not aligned to total size.
        set_cfg(64'h0800_0000, 1, 0, 1, 0, 0);
        probe("R5 misaligned", 64'h0800_0000);
        set_cfg(64'h0800_0000, 0, 1, 0, 0, 0);
        probe("R5 misaligned two-rank", 64'h0800_0008);
        // R6: 4 GB crossing and bad size code.
        set_cfg(64'h0, 5, 1, 1, 0, 0);
        probe("R6 cross 4GB", 64'h10);
        set_cfg(64'h0, 6, 0, 0, 0, 0);
        probe("R6 code above 5", 64'h10);
        set_cfg(64'h1_0000_0000, 5, 0, 1, 0, 0);
        probe("R6 4GB at 4GB ok", 64'h1_0000_0040);
        // R7: narrow area larger than half the rank.
        set_cfg(64'h1000_0000, 0, 1, 0, 65, 0);
        probe("R7 narrow too big", 64'h1000_0000);
        set_cfg(64'h1000_0000, 0, 1, 0, 64, 0);
        probe("R7 narrow at half", 64'h1000_0000);
        // R9: narrow area edges.
        probe("R9 last narrow byte", 64'h1000_0000 + 64'h3FF_FFFF);
        probe("R9 first wide byte", 64'h1000_0000 + 64'h400_0000);
        probe("R9 rank1 not narrow", 64'h1800_0000);
        set_cfg(64'h1000_0000, 0, 1, 0, 0, 0);
        probe("R9 zero size", 64'h1000_0000);
        // R10: 32-bit bus ignores the narrow size.
        set_cfg(64'h1000_0000, 0, 1, 1, 4000, 1);
        probe("R10 bus32 no err", 64'h1000_0000);
        probe("R10 bus32 no narrow", 64'h1000_2000);
        // R11: top of a 4 GB rank with 4 banks (largest row).
        set_cfg(64'h2_0000_0000, 5, 0, 0, 0, 0);
        probe("R11 max row", 64'h2_FFFF_FFF8);
        idle("R2 final idle");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule